// File: doc/BRIEF.md
# Multi-Channel Fan Tachometer Period Counter

This block measures fan speed on a set of tachometer inputs. Each input passes through a two-stage synchronizer and a rising-edge detector. A slow count clock then runs for a fixed number of tach pulses, two by default. The number of count-clock ticks seen in that window is published as a 13-bit period count. A larger count means a slower fan. When no edge arrives for long enough, the count saturates at its maximum, which flags a stalled fan.

Software uses a simple byte-wide register port with a registered read. Each channel's count is split into two adjacent registers. The even address returns the upper eight bits. The odd address returns the lower five bits in bits 4:0. Reading the upper register also captures the lower field, so an upper read followed by a lower read always gives one consistent sample.

A global enable and a per-channel enable gate the measurement. A per-channel pulses-per-revolution byte is kept for the reader, who computes speed as 1,350,000 / (count × ppr / 2).

Top module: `fan_tach_counter`

## Requirements
- R1: After reset the global control register reads 0x00, both channel-enable registers read 0x00, every ppr register reads 2, every upper count register reads 0xFF and every lower count register reads 0x1F.
- R2: The global control register is at address 0x00. Only bit 7 (global enable) is writable. Bits 6:0 always read 0.
- R3: While the global enable and the channel's enable are both set, the channel count equals the number of count-clock ticks between a rising tach edge and the rising edge two pulses later. The count clock runs at CLK_HZ / TICK_HZ system cycles per tick.
- R4: Channel n's count is read at address 0x40+2n, which returns count[12:5], and at 0x41+2n, which returns count[4:0] in bits 4:0 with bits 7:5 zero. A read returns data in the cycle after rd_en.
- R5: A read of channel n's upper register captures count[4:0] for that channel. Later reads of the lower register return the captured value until the next upper read, even if the count has changed.
- R6: Channel enables are at 0x01 (channels 0–7, bit n = channel n) and 0x02 (channels 8–15). A channel whose enable is clear keeps its last count, whatever its tach input does.
- R7: With the global enable clear, no channel's count changes.
- R8: An enabled channel whose tach input stops toggling reports a count of 0x1FFF once 8191 ticks have passed with no completed measurement.
- R9: The ppr register of channel n is at 0x20+n and can be read and written. Speed in RPM is 1,350,000 / (count × ppr / 2).
- R10: Writes to count register addresses have no effect on the values read there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_in | input | NUM_CH | Asynchronous tach inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |

## Verification
The bench drives three channels with different periods. The counts are chosen so that the 5-bit low field carries into the upper byte. An off-by-one in the window, or in which edges close it, would show up as an exact count mismatch. Packing the low field into the wrong bit position would corrupt both halves.

To test the low-field capture, the bench changes the period and then reads the low register without a new upper read. A design that reads the live count there returns the new value instead of the captured one.

Per-channel and global disables are tested while the input period changes. A design that keeps counting would publish the new period. Finally, one input is stopped. A counter that wraps instead of saturating would report a small, plausible count rather than 0x1FFF.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int GCTL_ADDR = 'h00;
  localparam int EN_BASE   = 'h01;
  localparam int PPR_BASE  = 'h20;
  localparam int CNT_BASE  = 'h40;
  localparam int GEN_BIT   = 7;
  localparam logic [DATA_W-1:0] PPR_RESET = 8'd2;
endpackage

// File: rtl/fan_tach_tick.sv
module fan_tach_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  generate
    if (DIV > 1) begin : g_gap
      // R3
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/fan_tach_sync.sv
module fan_tach_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;

  // R3
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/fan_tach_chan.sv
module fan_tach_chan #(
  parameter int CNT_W = 13,
  parameter int EDGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             rise,
  output logic [CNT_W-1:0] result
);
  localparam int EW = (EDGES > 1) ? $clog2(EDGES) : 1;
  localparam logic [EW-1:0] ELAST = EW'(EDGES - 1);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic             armed;
  logic [EW-1:0]    ecnt;
  logic [CNT_W-1:0] run;
  logic [CNT_W-1:0] run_inc;

  assign run_inc = (tick && run != MAXV) ? run + 1'b1 : run;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      ecnt   <= '0;
      run    <= '0;
      result <= MAXV;
    end else if (!en) begin
      armed <= 1'b0;
      ecnt  <= '0;
      run   <= '0;
    end else if (rise) begin
      if (!armed) begin
        armed <= 1'b1;
        ecnt  <= '0;
        run   <= '0;
      end else if (ecnt == ELAST) begin
        result <= run_inc;
        ecnt   <= '0;
        run    <= '0;
      end else begin
        ecnt <= ecnt + 1'b1;
        run  <= run_inc;
      end
    end else begin
      run <= run_inc;
      if (run_inc == MAXV) result <= MAXV;
    end
  end

  // R6
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(result));

  // R8
  stall_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !rise && run == MAXV) |=> (result == MAXV));
endmodule

// File: rtl/fan_tach_counter.sv
module fan_tach_counter
  import fan_tach_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int HI_W    = 8,
  parameter int LO_W    = 5,
  parameter int EDGES   = 2,
  parameter int CLK_HZ  = 100_000_000,
  parameter int TICK_HZ = 22_500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] tach_in,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [7:0]        rd_addr,
  output logic [7:0]        rd_data
);
  localparam int CNT_W   = HI_W + LO_W;
  localparam int DIV     = CLK_HZ / TICK_HZ;
  localparam int EN_REGS = (NUM_CH + 7) / 8;
  localparam int EN_W    = EN_REGS * 8;
  localparam logic [EN_W-1:0] EN_MASK = EN_W'({NUM_CH{1'b1}});

  logic              gen;
  logic [EN_W-1:0]   en_reg;
  logic [DATA_W-1:0] ppr     [NUM_CH];
  logic [LO_W-1:0]   lo_snap [NUM_CH];
  logic [CNT_W-1:0]  cnt     [NUM_CH];
  logic [DATA_W-1:0] rd_next;
  logic              tick;

  fan_tach_tick #(.DIV(DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic rise_c;
      fan_tach_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_in(tach_in[c]),
        .rise    (rise_c)
      );
      fan_tach_chan #(.CNT_W(CNT_W), .EDGES(EDGES)) u_chan (
        .clk   (clk),
        .rst   (rst),
        .en    (gen & en_reg[c]),
        .tick  (tick),
        .rise  (rise_c),
        .result(cnt[c])
      );
    end
  endgenerate

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      gen    <= 1'b0;
      en_reg <= '0;
      for (int c = 0; c < NUM_CH; c++) ppr[c] <= PPR_RESET;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(GCTL_ADDR)) gen <= wr_data[GEN_BIT];
      for (int k = 0; k < EN_REGS; k++)
        if (wr_addr == ADDR_W'(EN_BASE + k))
          en_reg[k*8 +: 8] <= wr_data & EN_MASK[k*8 +: 8];
      for (int c = 0; c < NUM_CH; c++)
        if (wr_addr == ADDR_W'(PPR_BASE + c)) ppr[c] <= wr_data;
    end
  end

  // read decode
  always_comb begin
    rd_next = '0;
    if (rd_addr == ADDR_W'(GCTL_ADDR)) rd_next[GEN_BIT] = gen;
    for (int k = 0; k < EN_REGS; k++)
      if (rd_addr == ADDR_W'(EN_BASE + k)) rd_next = en_reg[k*8 +: 8];
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == ADDR_W'(PPR_BASE + c)) rd_next = ppr[c];
      if (rd_addr == ADDR_W'(CNT_BASE + 2*c))
        rd_next = DATA_W'(cnt[c][CNT_W-1 -: HI_W]);
      if (rd_addr == ADDR_W'(CNT_BASE + 2*c + 1))
        rd_next = DATA_W'(lo_snap[c]);
    end
  end

  // registered read and low-field capture
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      for (int c = 0; c < NUM_CH; c++) lo_snap[c] <= '1;
    end else if (rd_en) begin
      rd_data <= rd_next;
      for (int c = 0; c < NUM_CH; c++)
        if (rd_addr == ADDR_W'(CNT_BASE + 2*c)) lo_snap[c] <= cnt[c][LO_W-1:0];
    end
  end

  // R2
  gctl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(GCTL_ADDR)) |=> (rd_data == {$past(gen), 7'b0}));

  // R2
  gctl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(GCTL_ADDR)) |=> (gen == $past(wr_data[GEN_BIT])));
endmodule

// File: tb/fan_tach_counter_tb.sv
module fan_tach_counter_tb;
  localparam int NCH = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] tach = '0;
  logic           wr_en = 1'b0;
  logic [7:0]     wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic           rd_en = 1'b0;
  logic [7:0]     rd_addr = '0;
  logic [7:0]     rd_data;

  int half [NCH];
  int ph   [NCH];
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  // Four system cycles per count tick: a half period of H cycles gives count H.
  fan_tach_counter #(.NUM_CH(NCH), .CLK_HZ(100_000_000), .TICK_HZ(25_000_000)) u_dut (
    .clk(clk), .rst(rst), .tach_in(tach),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial for (int i = 0; i < NCH; i++) begin half[i] = 0; ph[i] = 0; end

  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (half[i] != 0) begin
        if (ph[i] >= half[i] - 1) begin
          ph[i]   <= 0;
          tach[i] <= ~tach[i];
        end else begin
          ph[i] <= ph[i] + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 8'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rd_data);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_count(input int ch, output int hi, output int lo);
    rd(8'h40 + 2*ch, hi);
    rd(8'h41 + 2*ch, lo);
  endtask

  task automatic test_reset();
    int v, hi, lo;
    rd(8'h00, v); chk("R1 gctl", v, 0);
    rd(8'h01, v); chk("R1 en0", v, 0);
    rd(8'h02, v); chk("R1 en1", v, 0);
    rd(8'h23, v); chk("R1 ppr3", v, 2);
    read_count(0, hi, lo);
    chk("R1 hi", hi, 8'hFF);
    chk("R1 lo", lo, 8'h1F);
  endtask

  task automatic test_gctl();
    int v;
    wr(8'h00, 8'hFF);
    rd(8'h00, v); chk("R2 only bit7", v, 8'h80);
  endtask

  task automatic test_measure();
    int hi, lo;
    half[0] = 100; half[5] = 60; half[15] = 300;
    wr(8'h01, 8'hFF); wr(8'h02, 8'hFF);
    wait_cyc(3000);
    read_count(0, hi, lo);
    chk("R3 ch0 count", hi*32 + lo, 100);
    read_count(5, hi, lo);
    chk("R3 ch5 count", hi*32 + lo, 60);
    read_count(15, hi, lo);
    chk("R4 ch15 hi", hi, 9);
    chk("R4 ch15 lo", lo, 12);
  endtask

  task automatic test_snapshot();
    int hi, lo;
    half[15] = 100;
    wait_cyc(4000);
    rd(8'h41 + 30, lo); chk("R5 lo held", lo, 12);
    read_count(15, hi, lo);
    chk("R5 new hi", hi, 3);
    chk("R5 new lo", lo, 4);
  endtask

  task automatic test_chan_en();
    int hi, lo;
    wr(8'h01, 8'hDF);
    half[5] = 40; half[0] = 80;
    wait_cyc(1500);
    read_count(5, hi, lo);
    chk("R6 ch5 held", hi*32 + lo, 60);
    read_count(0, hi, lo);
    chk("R6 ch0 updates", hi*32 + lo, 80);
  endtask

  task automatic test_global();
    int hi, lo;
    wr(8'h00, 8'h00);
    half[0] = 120;
    wait_cyc(1500);
    read_count(0, hi, lo);
    chk("R7 ch0 held", hi*32 + lo, 80);
    wr(8'h00, 8'h80);
    wait_cyc(1500);
    read_count(0, hi, lo);
    chk("R7 ch0 resumes", hi*32 + lo, 120);
  endtask

  task automatic test_ppr_rpm();
    int v, hi, lo, rpm_dut, rpm_exp;
    wr(8'h20, 4);
    rd(8'h20, v); chk("R9 ppr rw", v, 4);
    read_count(0, hi, lo);
    rpm_dut = 1350000 / (((hi*32 + lo) * v) / 2);
    rpm_exp = 1350000 / ((120 * 4) / 2);
    chk("R9 rpm", rpm_dut, rpm_exp);
  endtask

  task automatic test_ro();
    int hi, lo;
    wr(8'h40, 8'h00);
    wr(8'h41, 8'h00);
    read_count(0, hi, lo);
    chk("R10 hi unchanged", hi, 3);
    chk("R10 lo unchanged", lo, 24);
  endtask

  task automatic test_stall();
    int hi, lo;
    half[15] = 0;
    wait_cyc(34000);
    read_count(15, hi, lo);
    chk("R8 stall hi", hi, 8'hFF);
    chk("R8 stall lo", lo, 8'h1F);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_gctl();
    test_measure();
    test_snapshot();
    test_chan_en();
    test_global();
    test_ppr_rpm();
    test_ro();
    test_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule